// File: doc/BRIEF.md
# Serial CRC-5 Long-Division Register

This block divides a serial bit stream, modulo 2, by the fixed degree-5 generator x^5 + x^4 + x^2 + 1 (binary 110101). One bit is taken per accepted clock, most significant bit first. The five-bit remainder is always visible on an output port. After every accepted bit it is the remainder of the bits seen so far.

To generate a checksum, the sender clears the register and presents the message bits. It then presents five zero bits and reads the residue port. The value there is the checksum, to be sent after the message. To check a received codeword, the receiver clears the register and feeds in the message followed by its checksum. A flag is high whenever the residue is all zeros, so a clean codeword leaves the flag high.

The stream input uses a valid/ready handshake. A bit is consumed on any rising edge where valid and ready are both high. Ready falls only while the synchronous clear is asserted. The source may therefore hold a bit with valid for as long as it likes, and an idle cycle never disturbs the remainder. The block never stalls a stream apart from during a clear.

Top module: `crc5_serial_divider`

## Requirements
- R1: When `clr` is high at a rising edge, `residue` is 00000 after that edge, whatever `bit_valid` and `bit_data` are.
- R2: When `clr` is low and `bit_valid` is low at a rising edge, `residue` keeps its value, whatever `bit_data` is.
- R3: At an edge where a bit is accepted and `residue[4]` is 0, the new `residue` is the old `residue[3:0]` with `bit_data` appended as bit 0.
- R4: At an edge where a bit is accepted and `residue[4]` is 1, the new `residue` is the old `residue[3:0]` with `bit_data` appended as bit 0, XORed with 10101.
- R5: After a clear, the input 1010001101 followed by 00000 (leftmost bit first) steps `residue` through 00001, 00010, 00101, 01010, 10100, 11101, 01110, 11101, 01111, 11111, 01011, 10110, 11001, 00111 and 01110, so the checksum is 01110.
- R6: After a clear, the codeword 101000110101110 leaves `residue` at 00000 after its 15 bits.
- R7: `residue_zero` is high exactly when all five bits of `residue` are 0, in the same cycle.
- R8: `bit_ready` is low while `clr` is high and high otherwise. A bit is accepted only at an edge where `bit_valid` and `bit_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear of the remainder; wins over a shift |
| bit_valid | input | 1 | A stream bit is offered on `bit_data` |
| bit_data | input | 1 | Serial dividend bit, most significant first |
| bit_ready | output | 1 | Block can accept a bit this cycle |
| residue | output | 5 | Current remainder, bit 4 is the oldest |
| residue_zero | output | 1 | High when `residue` is 00000 |

## Verification
The case that is hardest to reach from the ports is a fold in which the incoming bit is also 1. In that case the XOR into bit 0 cancels the data bit. That needs a residue with bit 4 set at the same moment a 1 arrives. A clear that lands on a cycle with a valid bit pending is also hard to arrange. The stimulus plays the full 15-step division trace, which contains several folds. It then runs a long random stream with random valid gaps, so folds meet both data values many times. Finally it drives clear and valid high together while the residue is nonzero.

// File: rtl/crc5_div_pkg.sv
package crc5_div_pkg;
  // remainder width equals generator degree
  localparam int unsigned CRC_W = 5;
  // generator 110101 without its implicit top term
  localparam logic [CRC_W-1:0] GEN_LOW = 5'b10101;
endpackage

// File: rtl/crc_div_step.sv
// One long-division step: shift left, insert the new bit, fold on carry-out.
module crc_div_step #(
  parameter int unsigned W = crc5_div_pkg::CRC_W,
  parameter logic [W-1:0] POLY = crc5_div_pkg::GEN_LOW
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic carry;
  assign carry = cur[W-1];

  assign nxt[0] = din ^ (carry & POLY[0]);

  for (genvar i = 1; i < W; i++) begin : g_tap
    if (POLY[i]) begin : g_xor
      assign nxt[i] = cur[i-1] ^ carry;
    end else begin : g_pass
      assign nxt[i] = cur[i-1];
    end
  end
endmodule

// File: rtl/crc_div_reg.sv
// Remainder storage with synchronous clear taking priority over load.
module crc_div_reg #(
  parameter int unsigned W = crc5_div_pkg::CRC_W
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (clr) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/crc_div_zero.sv
// All-zero detect on the remainder.
module crc_div_zero #(
  parameter int unsigned W = crc5_div_pkg::CRC_W
) (
  input  logic [W-1:0] val,
  output logic         zero
);
  assign zero = ~|val;
endmodule

// File: rtl/crc5_serial_divider.sv
module crc5_serial_divider #(
  parameter int unsigned W = crc5_div_pkg::CRC_W,
  parameter logic [W-1:0] POLY = crc5_div_pkg::GEN_LOW
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         bit_valid,
  input  logic         bit_data,
  output logic         bit_ready,
  output logic [W-1:0] residue,
  output logic         residue_zero
);
  logic         take;
  logic [W-1:0] step_out;

  // stream accepts whenever no clear is in progress
  assign bit_ready = ~clr;
  assign take      = bit_valid & bit_ready;

  crc_div_step #(.W(W), .POLY(POLY)) u_step (
    .cur (residue),
    .din (bit_data),
    .nxt (step_out)
  );

  crc_div_reg #(.W(W)) u_reg (
    .clk (clk),
    .clr (clr),
    .en  (take),
    .d   (step_out),
    .q   (residue)
  );

  crc_div_zero #(.W(W)) u_zero (
    .val  (residue),
    .zero (residue_zero)
  );
endmodule

// File: rtl/crc5_serial_divider_chk.sv
module crc5_serial_divider_chk #(
  parameter int unsigned W = crc5_div_pkg::CRC_W,
  parameter logic [W-1:0] POLY = crc5_div_pkg::GEN_LOW
) (
  input logic         clk,
  input logic         clr,
  input logic         bit_valid,
  input logic         bit_data,
  input logic         bit_ready,
  input logic [W-1:0] residue,
  input logic         residue_zero
);
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (clr) armed <= 1'b1;
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (!armed && !clr)
    clr |=> (residue == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (clr || !armed)
    (!bit_valid) |=> $stable(residue));

  p_shift_r3: assert property (@(posedge clk) disable iff (clr || !armed)
    (bit_valid && !residue[W-1]) |=>
      (residue == {$past(residue[W-2:0]), $past(bit_data)}));

  p_fold_r4: assert property (@(posedge clk) disable iff (clr || !armed)
    (bit_valid && residue[W-1]) |=>
      (residue == ({$past(residue[W-2:0]), $past(bit_data)} ^ POLY)));

  always_ff @(negedge clk) begin
    if (armed) begin
      p_zero_flag_r7: assert (residue_zero == (residue == '0));
    end
    p_ready_r8: assert (bit_ready == !clr);
  end
endmodule

bind crc5_serial_divider crc5_serial_divider_chk #(.W(W), .POLY(POLY)) u_chk (
  .clk          (clk),
  .clr          (clr),
  .bit_valid    (bit_valid),
  .bit_data     (bit_data),
  .bit_ready    (bit_ready),
  .residue      (residue),
  .residue_zero (residue_zero)
);

// File: tb/sim_crc5_serial_divider.sv
`timescale 1ns/1ps
module sim_crc5_serial_divider;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b0;
  logic       bit_ready;
  logic [4:0] residue;
  logic       residue_zero;

  always #4 clk = ~clk;  // 125 MHz

  crc5_serial_divider u0 (
    .clk(clk), .clr(clr), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .residue(residue), .residue_zero(residue_zero)
  );

  typedef struct {
    logic [4:0] exp;
    string      tag;
  } item_t;

  item_t      sb[$];
  int         n_chk = 0;
  int         n_bad = 0;
  logic [4:0] mdl = '0;
  logic       acc_q = 1'b0;
  bit         done = 1'b0;

  function automatic logic [4:0] model_step(logic [4:0] s, logic b);
    logic [4:0] t;
    t = {s[3:0], b};
    if (s[4]) t = t ^ 5'b10101;
    return t;
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // driver: presents one bit and queues the residue it must produce
  task automatic send(logic b, string tag, logic [4:0] exp);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_data  = b;
    sb.push_back('{exp, tag});
    mdl = exp;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b0;
      bit_data  = ~bit_data;
    end
  endtask

  // monitor: records acceptance at the edge, compares half a cycle later
  always @(posedge clk) acc_q <= bit_valid && !clr;

  always @(negedge clk) begin
    if (acc_q) begin
      if (sb.size() == 0) begin
        check("R8 unexpected accept", residue, 5'bx);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, residue, it.exp);
        check("R7 flag", {4'b0, residue_zero}, {4'b0, (it.exp == 5'b0)});
      end
    end
  end

  initial begin
    logic [4:0]  trace [15];
    logic [14:0] msg;
    logic [14:0] cw;
    trace = '{5'b00001, 5'b00010, 5'b00101, 5'b01010, 5'b10100,
              5'b11101, 5'b01110, 5'b11101, 5'b01111, 5'b11111,
              5'b01011, 5'b10110, 5'b11001, 5'b00111, 5'b01110};
    msg = 15'b101000110100000;
    cw  = 15'b101000110101110;

    // reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset residue", residue, 5'b0);
    check("R7 flag after reset", {4'b0, residue_zero}, 5'b1);
    check("R8 ready low in clear", {4'b0, bit_ready}, 5'b0);
    clr = 1'b0;
    #1;
    check("R8 ready high", {4'b0, bit_ready}, 5'b1);

    // R5 checksum generation trace
    for (int i = 0; i < 15; i++) send(msg[14-i], "R5 trace", trace[i]);
    idle(1);
    @(negedge clk);
    check("R5 checksum", residue, 5'b01110);
    check("R7 flag nonzero", {4'b0, residue_zero}, 5'b0);

    // R2 idle cycles with data toggling
    idle(4);
    check("R2 hold", residue, 5'b01110);

    // R6 codeword check
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    mdl = '0;
    for (int i = 0; i < 15; i++) send(cw[14-i], "R6 codeword", model_step(mdl, cw[14-i]));
    idle(1);
    @(negedge clk);
    check("R6 residue zero", residue, 5'b0);
    check("R7 flag on clean codeword", {4'b0, residue_zero}, 5'b1);

    // random stream, shift vs fold
    for (int i = 0; i < 400; i++) begin
      logic b;
      b = 1'($urandom);
      if ($urandom_range(3) == 0) idle(1);
      send(b, mdl[4] ? "R4 fold" : "R3 shift", model_step(mdl, b));
    end
    idle(1);

    // R1 clear beats a pending valid bit; force a nonzero residue first
    send(1'b1, mdl[4] ? "R4 fold" : "R3 shift", model_step(mdl, 1'b1));
    send(1'b1, mdl[4] ? "R4 fold" : "R3 shift", model_step(mdl, 1'b1));
    @(negedge clk);
    clr = 1'b1;
    bit_valid = 1'b1;
    bit_data  = 1'b1;
    #1;
    check("R8 ready low with valid", {4'b0, bit_ready}, 5'b0);
    @(negedge clk);
    check("R1 clear over valid", residue, 5'b0);
    clr = 1'b0;
    bit_valid = 1'b0;
    idle(2);
    check("R8 scoreboard drained", 5'(sb.size()), 5'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule